// File: doc/BRIEF.md
# Seconds Real-Time Clock Core

This core keeps time as a plain binary count of seconds. A 32-bit counter advances once per second. The second comes from an external one-second tick, or from an internal prescaler that divides the core clock. Software sees the counter, an alarm compare word, a divider word, a scratch word, a reset-record word and two small control words through a simple 32-bit register port. The port has a byte address, a write enable, write data and read data that returns in the same cycle. Writes take effect on the next rising clock edge.

The control word and the charger word are written through a mask. The upper half of the write data says which bits of the lower half may change, so software can alter one field without reading first. The count is loaded through one address and read through another. When the counter steps onto a non-zero alarm value with the alarm enabled, the core emits a one-cycle interrupt pulse, which the host senses as a rising edge. The same pulse can also go to a wake output for power management.

There are two resets. The power-on reset (asynchronous, active low) clears everything. The system reset (synchronous, active low) clears the counter and the alarm, but only when the keep-time bit in the control word is clear.

Top module: `rtc_seconds_core`

## Requirements
- R1: While the power-on reset is asserted, the interrupt and wake outputs are 0 and the charger outputs are 0. When the reset is released, every readable register reads 0.
- R2: Control word at 0x40, six bits: bit 0 alarm enable, bit 1 route alarm to the wake output, bit 2 overdue-alarm enable (stored only), bit 3 slow-oscillator mode reset (stored only), bit 4 keep time through system reset, bit 5 freeze counter. A write changes lower bit n only when bit n+16 of the same write data is 1. Reads return 0 in bits 31:6.
- R3: Charger word at 0x5C, four bits, written with the same mask scheme: bits 3:2 resistor select, bit 1 diode select, bit 0 charge enable. It is driven on the chargeCfg output. Bits 31:4 read as 0.
- R4: The counter is read at 0x44 and loaded by a write to 0x4C. Writes to 0x44 are ignored, and reads of 0x4C return 0.
- R5: When the divider word is 0, the counter advances by one at each clock edge where tickIn is 1, and wraps from 0xFFFFFFFF to 0.
- R6: The divider word at 0x48 holds a value N. When N is not zero, the counter advances once every N clock edges and tickIn is ignored. A write to 0x48 restarts the prescaler, so the first advance comes on the Nth edge after the write edge.
- R7: While the freeze bit is 1 the counter does not advance, but a load through 0x4C still takes effect.
- R8: alarmIrq pulses high for exactly one cycle: the cycle in which an advance has just made the counter equal to the alarm word at 0x50. This needs a non-zero alarm word and the alarm enable bit set. No pulse comes when the alarm word is 0, when the enable bit is clear, or when the value is reached by a load.
- R9: pmcWake pulses together with alarmIrq only when control bit 1 is 1.
- R10: A system reset clears the counter and the alarm word when control bit 4 is 0, and leaves both unchanged when it is 1. The control, charger, divider and user words are never affected by it.
- R11: The user word at 0x54 stores and returns any 32-bit value.
- R12: Reset record at 0x58: bit 0 is set by any system reset, and bit 1 is set by a system reset that occurs while bit 4 of the control word is 1. Writing 1 to a record bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| sysRstN | input | 1 | System reset, synchronous, active low |
| tickIn | input | 1 | One-second tick, used when the divider word is 0 |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data, with the mask half for the control and charger words |
| busRdata | output | 32 | Read data for busAddr, same cycle |
| alarmIrq | output | 1 | One-cycle alarm pulse |
| pmcWake | output | 1 | Alarm pulse routed to power management |
| chargeCfg | output | 4 | Charger select and enable bits |

## Verification
The masked control path is driven with fixed patterns and with random mask/data pairs. This separates a design that honours the mask per bit from one that writes the whole word or that ignores mask bits. The counter is loaded with random values and then given random burst lengths of ticks, which catches off-by-one and wrap errors. Directed runs near 0xFFFFFFFF and through the internal divider check the rollover and the prescaler phase. The alarm is hit by ticking, and left alone when the value is reached by a load, with a zero alarm word and with the enable bit clear, which separates the match condition from plain equality. System resets are applied with the keep bit both clear and set.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  // register byte offsets
  localparam logic [7:0] OFF_CTRL  = 8'h40;
  localparam logic [7:0] OFF_COUNT = 8'h44;
  localparam logic [7:0] OFF_DIV   = 8'h48;
  localparam logic [7:0] OFF_SET   = 8'h4C;
  localparam logic [7:0] OFF_ALARM = 8'h50;
  localparam logic [7:0] OFF_USER  = 8'h54;
  localparam logic [7:0] OFF_REC   = 8'h58;
  localparam logic [7:0] OFF_CHG   = 8'h5C;

  localparam int CTRL_BITS = 6;
  localparam int CHG_BITS  = 4;
  localparam int REC_BITS  = 2;

  // control word bit positions
  localparam int B_ALM_EN   = 0;
  localparam int B_PMC      = 1;
  localparam int B_OVERDUE  = 2;
  localparam int B_MODE_RST = 3;
  localparam int B_KEEP     = 4;
  localparam int B_FREEZE   = 5;

  // control -> datapath
  typedef struct packed {
    logic setCnt;
    logic setAlarm;
    logic setDiv;
    logic freeze;
    logic alarmEn;
    logic pmcRoute;
    logic keepOnSys;
  } rtcStrobe_t;

endpackage

// File: rtl/rtc_sec_ctrl.sv
module rtc_sec_ctrl
  import rtc_sec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 sysRstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [DATA_W-1:0]    cntQ,
  input  logic [DATA_W-1:0]    alarmQ,
  input  logic [DATA_W-1:0]    divQ,
  output rtcStrobe_t           stb,
  output logic [DATA_W-1:0]    busRdata,
  output logic [CHG_BITS-1:0]  chargeCfg,
  output logic [CTRL_BITS-1:0] ctrlBits
);
  localparam int HALF = DATA_W / 2;

  logic [CTRL_BITS-1:0] ctrlQ;
  logic [CHG_BITS-1:0]  chgQ;
  logic [REC_BITS-1:0]  recQ;
  logic [DATA_W-1:0]    userQ;

  logic hitCtrl, hitChg, hitUser, hitRec;

  assign hitCtrl = busWe && (busAddr == ADDR_W'(OFF_CTRL));
  assign hitChg  = busWe && (busAddr == ADDR_W'(OFF_CHG));
  assign hitUser = busWe && (busAddr == ADDR_W'(OFF_USER));
  assign hitRec  = busWe && (busAddr == ADDR_W'(OFF_REC));

  // masked control word: bit n follows data only when bit n+HALF is set
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      ctrlQ <= '0;
    end else if (hitCtrl) begin
      for (int i = 0; i < CTRL_BITS; i++) begin
        if (busWdata[HALF+i]) ctrlQ[i] <= busWdata[i];
      end
    end
  end

  // masked charger word
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      chgQ <= '0;
    end else if (hitChg) begin
      for (int i = 0; i < CHG_BITS; i++) begin
        if (busWdata[HALF+i]) chgQ[i] <= busWdata[i];
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)     userQ <= '0;
    else if (hitUser) userQ <= busWdata;
  end

  // reset record: sticky, write one to clear
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)      recQ <= '0;
    else if (!sysRstN) recQ <= recQ | {ctrlQ[B_KEEP], 1'b1};
    else if (hitRec)   recQ <= recQ & ~busWdata[REC_BITS-1:0];
  end

  always_comb begin
    stb           = '0;
    stb.setCnt    = busWe && (busAddr == ADDR_W'(OFF_SET));
    stb.setAlarm  = busWe && (busAddr == ADDR_W'(OFF_ALARM));
    stb.setDiv    = busWe && (busAddr == ADDR_W'(OFF_DIV));
    stb.freeze    = ctrlQ[B_FREEZE];
    stb.alarmEn   = ctrlQ[B_ALM_EN];
    stb.pmcRoute  = ctrlQ[B_PMC];
    stb.keepOnSys = ctrlQ[B_KEEP];
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_CTRL):  busRdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrlQ};
      ADDR_W'(OFF_COUNT): busRdata = cntQ;
      ADDR_W'(OFF_DIV):   busRdata = divQ;
      ADDR_W'(OFF_ALARM): busRdata = alarmQ;
      ADDR_W'(OFF_USER):  busRdata = userQ;
      ADDR_W'(OFF_REC):   busRdata = {{(DATA_W-REC_BITS){1'b0}}, recQ};
      ADDR_W'(OFF_CHG):   busRdata = {{(DATA_W-CHG_BITS){1'b0}}, chgQ};
      default:            busRdata = '0;
    endcase
  end

  assign chargeCfg = chgQ;
  assign ctrlBits  = ctrlQ;

endmodule

// File: rtl/rtc_sec_datapath.sv
module rtc_sec_datapath
  import rtc_sec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter bit DIV_EN = 1'b1
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              tickIn,
  input  rtcStrobe_t        stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] alarmQ,
  output logic [DATA_W-1:0] divQ,
  output logic              alarmIrq,
  output logic              pmcWake
);
  logic              secTick;
  logic              sysClr;
  logic              advance;
  logic              hitAlarm;
  logic [DATA_W-1:0] nextCnt;

  assign sysClr = !sysRstN && !stb.keepOnSys;

  generate
    if (DIV_EN) begin : g_prescale
      localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);
      logic [DIV_W-1:0] divReg;
      logic [DIV_W-1:0] phase;
      logic             wrapPhase;

      assign wrapPhase = (phase == divReg - ONE_D);

      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) begin
          divReg <= '0;
          phase  <= '0;
        end else if (stb.setDiv) begin
          divReg <= busWdata[DIV_W-1:0];
          phase  <= '0;
        end else if (divReg != '0) begin
          phase <= wrapPhase ? '0 : phase + ONE_D;
        end
      end

      assign secTick = (divReg != '0) ? wrapPhase : tickIn;
      assign divQ    = {{(DATA_W-DIV_W){1'b0}}, divReg};
    end else begin : g_ext_only
      assign secTick = tickIn;
      assign divQ    = '0;
    end
  endgenerate

  assign nextCnt  = cntQ + DATA_W'(1);
  assign advance  = secTick && !stb.freeze && !sysClr && !stb.setCnt;
  assign hitAlarm = advance && stb.alarmEn && (alarmQ != '0) && (nextCnt == alarmQ);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)        cntQ <= '0;
    else if (sysClr)     cntQ <= '0;
    else if (stb.setCnt) cntQ <= busWdata;
    else if (advance)    cntQ <= nextCnt;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          alarmQ <= '0;
    else if (sysClr)       alarmQ <= '0;
    else if (stb.setAlarm) alarmQ <= busWdata;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      alarmIrq <= 1'b0;
      pmcWake  <= 1'b0;
    end else begin
      alarmIrq <= hitAlarm;
      pmcWake  <= hitAlarm && stb.pmcRoute;
    end
  end

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_sec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16,
  parameter bit DIV_EN = 1'b1
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                sysRstN,
  input  logic                tickIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                alarmIrq,
  output logic                pmcWake,
  output logic [CHG_BITS-1:0] chargeCfg
);
  rtcStrobe_t           stb;
  logic [DATA_W-1:0]    cntQ;
  logic [DATA_W-1:0]    alarmQ;
  logic [DATA_W-1:0]    divQ;
  logic [CTRL_BITS-1:0] ctrlBits;

  rtc_sec_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .cntQ     (cntQ),
    .alarmQ   (alarmQ),
    .divQ     (divQ),
    .stb      (stb),
    .busRdata (busRdata),
    .chargeCfg(chargeCfg),
    .ctrlBits (ctrlBits)
  );

  rtc_sec_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_EN(DIV_EN)) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .tickIn   (tickIn),
    .stb      (stb),
    .busWdata (busWdata),
    .cntQ     (cntQ),
    .alarmQ   (alarmQ),
    .divQ     (divQ),
    .alarmIrq (alarmIrq),
    .pmcWake  (pmcWake)
  );

endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk
  import rtc_sec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 porRstN,
  input logic                 sysRstN,
  input logic                 busWe,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic                 alarmIrq,
  input logic                 pmcWake,
  input logic [DATA_W-1:0]    cntQ,
  input logic [DATA_W-1:0]    alarmQ,
  input logic [CTRL_BITS-1:0] ctrlBits
);
  localparam int HALF = DATA_W / 2;

  logic ctrlWrNoMask, setWr;
  assign ctrlWrNoMask = busWe && (busAddr == ADDR_W'(OFF_CTRL)) &&
                        (busWdata[HALF +: CTRL_BITS] == '0);
  assign setWr = busWe && (busAddr == ADDR_W'(OFF_SET));

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!porRstN)
    alarmIrq |=> !alarmIrq); // R8

  AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!porRstN)
    alarmIrq |-> (cntQ == $past(alarmQ)) && ($past(alarmQ) != '0)); // R8

  AST_WAKE_WITH_IRQ: assert property (@(posedge clk) disable iff (!porRstN)
    pmcWake |-> alarmIrq); // R9

  AST_CTRL_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    ctrlWrNoMask |=> $stable(ctrlBits)); // R2

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    (ctrlBits[B_FREEZE] && sysRstN && !setWr) |=> $stable(cntQ)); // R7

  AST_KEEP_ALARM: assert property (@(posedge clk) disable iff (!porRstN)
    (!sysRstN && ctrlBits[B_KEEP] && !busWe) |=> $stable(alarmQ)); // R10

  AST_SYSRST_CLEAR: assert property (@(posedge clk) disable iff (!porRstN)
    (!sysRstN && !ctrlBits[B_KEEP]) |=> (cntQ == '0) && (alarmQ == '0)); // R10

endmodule

bind rtc_seconds_core rtc_seconds_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .sysRstN  (sysRstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .alarmIrq (alarmIrq),
  .pmcWake  (pmcWake),
  .cntQ     (cntQ),
  .alarmQ   (alarmQ),
  .ctrlBits (ctrlBits)
);

// File: tb/rtc_seconds_core_bench.sv
module rtc_seconds_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        tickIn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        alarmIrq, pmcWake;
  logic [3:0]  chargeCfg;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0;
  int wakeSeen = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_core u_rtc_seconds_core (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickIn(tickIn),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .alarmIrq(alarmIrq), .pmcWake(pmcWake), .chargeCfg(chargeCfg)
  );

  always @(negedge clk) begin
    if (alarmIrq) irqSeen++;
    if (pmcWake)  wakeSeen++;
  end

  function automatic logic [31:0] maskedMerge(input logic [31:0] oldV, input logic [31:0] w,
                                              input int bits);
    logic [31:0] m;
    m = (w >> 16) & ((32'd1 << bits) - 1);
    return (oldV & ~m) | (w & m);
  endfunction

  function automatic logic [31:0] afterTicks(input logic [31:0] start, input int n);
    return start + 32'(n);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickIn = 1'b1;
    repeat (n) @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic sysReset();
    @(negedge clk);
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] expCtrl, v, w, ud;
    int n;
    void'($urandom(32'd4242));

    // R1 power-on reset
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, alarmIrq}, 32'd0);
    check("R1 chargeCfg in reset", {28'd0, chargeCfg}, 32'd0);
    porRstN = 1'b1;
    @(negedge clk);
    rdCheck("R1 ctrl", 8'h40, 0);
    rdCheck("R1 count", 8'h44, 0);
    rdCheck("R1 div", 8'h48, 0);
    rdCheck("R1 alarm", 8'h50, 0);
    rdCheck("R1 user", 8'h54, 0);
    rdCheck("R1 record", 8'h58, 0);
    rdCheck("R1 charger", 8'h5C, 0);

    // R2 masked control writes
    wr(8'h40, 32'h003F_0021); rdCheck("R2 full mask", 8'h40, 32'h21);
    wr(8'h40, 32'h0000_003F); rdCheck("R2 no mask", 8'h40, 32'h21);
    wr(8'h40, 32'h0001_0000); rdCheck("R2 single bit", 8'h40, 32'h20);
    expCtrl = 32'h20;
    for (int i = 0; i < 24; i++) begin
      w = $urandom;
      wr(8'h40, w);
      expCtrl = maskedMerge(expCtrl, w, 6);
      rdCheck("R2 random mask", 8'h40, expCtrl);
    end
    wr(8'h40, 32'h003F_0000); rdCheck("R2 clear", 8'h40, 0);

    // R3 charger word
    wr(8'h5C, 32'h000F_000B); rdCheck("R3 write", 8'h5C, 32'hB);
    check("R3 port", {28'd0, chargeCfg}, 32'hB);
    wr(8'h5C, 32'h0002_0000); rdCheck("R3 diode bit", 8'h5C, 32'h9);
    wr(8'h5C, 32'h0000_00FF); rdCheck("R3 no mask", 8'h5C, 32'h9);
    wr(8'h5C, 32'h00F0_00F0); rdCheck("R3 upper bits", 8'h5C, 32'h9);
    check("R3 port after", {28'd0, chargeCfg}, 32'h9);

    // R11 user word
    ud = $urandom;
    wr(8'h54, ud); rdCheck("R11 user", 8'h54, ud);

    // R4 load and read addresses
    wr(8'h4C, 32'd100);
    rdCheck("R4 load", 8'h44, 32'd100);
    rdCheck("R4 set reads 0", 8'h4C, 0);
    wr(8'h44, 32'd5);
    rdCheck("R4 write to count ignored", 8'h44, 32'd100);

    // R5 external ticks and wrap
    ticks(7);
    rdCheck("R5 ticks", 8'h44, 32'd107);
    wr(8'h4C, 32'hFFFF_FFFE);
    ticks(3);
    rdCheck("R5 wrap", 8'h44, 32'd1);
    for (int i = 0; i < 12; i++) begin
      v = $urandom;
      n = int'($urandom % 20) + 1;
      wr(8'h4C, v);
      ticks(n);
      rdCheck("R5 random burst", 8'h44, afterTicks(v, n));
    end

    // R7 freeze
    wr(8'h4C, 32'd500);
    wr(8'h40, 32'h0020_0020);
    ticks(5);
    rdCheck("R7 frozen", 8'h44, 32'd500);
    wr(8'h4C, 32'd42);
    rdCheck("R7 load while frozen", 8'h44, 32'd42);
    wr(8'h40, 32'h0020_0000);
    ticks(1);
    rdCheck("R7 resumes", 8'h44, 32'd43);

    // R6 internal divider
    wr(8'h4C, 32'd0);
    wr(8'h48, 32'd4);
    tickIn = 1'b1;
    repeat (12) @(negedge clk);
    tickIn = 1'b0;
    rdCheck("R6 div readback", 8'h48, 32'd4);
    rdCheck("R6 divided count", 8'h44, 32'd3);
    wr(8'h48, 32'd0);

    // R8 alarm on tick
    wr(8'h40, 32'h0003_0001);
    wr(8'h4C, 32'd10);
    wr(8'h50, 32'd13);
    irqSeen = 0; wakeSeen = 0;
    ticks(3);
    check("R8 irq at match", {31'd0, alarmIrq}, 32'd1);
    rdCheck("R8 count at irq", 8'h44, 32'd13);
    @(negedge clk);
    check("R8 irq one cycle", {31'd0, alarmIrq}, 32'd0);
    ticks(2);
    check("R8 single pulse", 32'(irqSeen), 32'd1);
    check("R9 no wake when unrouted", 32'(wakeSeen), 32'd0);

    // R8 zero alarm never fires
    irqSeen = 0;
    wr(8'h50, 32'd0);
    wr(8'h4C, 32'hFFFF_FFFE);
    ticks(4);
    check("R8 zero alarm", 32'(irqSeen), 32'd0);

    // R8 disabled
    wr(8'h40, 32'h0001_0000);
    wr(8'h50, 32'd20);
    wr(8'h4C, 32'd18);
    ticks(4);
    check("R8 disabled", 32'(irqSeen), 32'd0);

    // R8 reached by load
    wr(8'h40, 32'h0001_0001);
    wr(8'h50, 32'd50);
    wr(8'h4C, 32'd50);
    repeat (2) @(negedge clk);
    check("R8 load no irq", 32'(irqSeen), 32'd0);

    // R9 routed to wake
    wr(8'h40, 32'h0002_0002);
    wr(8'h50, 32'd60);
    wr(8'h4C, 32'd58);
    irqSeen = 0; wakeSeen = 0;
    ticks(3);
    @(negedge clk);
    check("R9 irq", 32'(irqSeen), 32'd1);
    check("R9 wake", 32'(wakeSeen), 32'd1);

    // R10 / R12 system reset without keep
    wr(8'h4C, 32'd77);
    wr(8'h50, 32'd88);
    sysReset();
    rdCheck("R10 count cleared", 8'h44, 0);
    rdCheck("R10 alarm cleared", 8'h50, 0);
    rdCheck("R10 user kept", 8'h54, ud);
    rdCheck("R10 ctrl kept", 8'h40, 32'h03);
    rdCheck("R10 charger kept", 8'h5C, 32'h9);
    rdCheck("R12 record plain", 8'h58, 32'h1);
    wr(8'h58, 32'h3);
    rdCheck("R12 record cleared", 8'h58, 0);

    // R10 / R12 system reset with keep
    wr(8'h40, 32'h0010_0010);
    wr(8'h4C, 32'd77);
    wr(8'h50, 32'd88);
    sysReset();
    rdCheck("R10 count kept", 8'h44, 32'd77);
    rdCheck("R10 alarm kept", 8'h50, 32'd88);
    rdCheck("R12 record protected", 8'h58, 32'h3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule